// File: doc/BRIEF.md
# Two-Write Four-Read Register File with Live Value Table

This block is the general-purpose register file of a pipelined 32-bit processor. It holds sixteen 32-bit registers and takes up to two writes and four reads in every clock cycle. An instruction that has to update two registers at once, such as a stack pop that loads a value and also moves the stack pointer, can therefore retire both results in a single cycle.

No single storage array has two write ports. Each write port has its own copy of the register contents, and that copy is repeated once for every read port, so each storage bank has exactly one write port and one read port. A small table holds one entry per register. Each entry records which write port last stored that register, and every read port uses the table to pick the bank that holds the current value. Reads are combinational on the address. After the bank is chosen, a forwarding stage hands over data that a write port is presenting in the same cycle, so the pipeline needs no bubble between a write and a dependent read.

Top module: `lvt_regfile`

## Requirements
- R1: Two enabled write ports with different addresses both take effect at the same rising clock edge. Each register then reads back its own written value.
- R2: The four read ports are independent and combinational. Each port returns the contents of the register at its own address in the same cycle, whatever addresses the other ports use.
- R3: When an enabled write port targets the address of a read port in the same cycle, that read port returns the write data at once. The value read is not the stored one.
- R4: When both write ports are enabled for the same register in one cycle, write port 1 (index 1) wins. Its data is forwarded in that cycle and is the value read in later cycles.
- R5: While reset is asserted, and after it is released, every register reads as zero and every table entry selects write port 0.
- R6: A write port with its enable low changes no register and no table entry, and forwards nothing, whatever its address and data are.
- R7: A register always reads the value from its most recent write, whichever port made that write. A later write from port 0 overrides an earlier write from port 1, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| wr_en | input | 2 | Write enable, one bit for each write port |
| wr_addr | input | 2x4 | Register address for each write port |
| wr_data | input | 2x32 | Write data for each write port |
| rd_addr | input | 4x4 | Register address for each read port |
| rd_data | output | 4x32 | Read data for each read port, combinational |

## Verification
A wrong table entry does not show until a register is read after a write. The read then returns the older value from the other port's bank, on the first read one cycle after the faulty edge. For that reason the tests write a register from one port and then overwrite it from the other port, and they check the collision case in both the same cycle and the next one. A fault in forwarding shows only in the write cycle itself. A fault in a single bank copy shows on only one read port, so every check reads the register on all four ports.

// File: rtl/lvt_rf_pkg.sv
package lvt_rf_pkg;
  localparam int RF_DATA_W   = 32;
  localparam int RF_DEPTH    = 16;
  localparam int RF_WR_PORTS = 2;
  localparam int RF_RD_PORTS = 4;

  function automatic int clog2_min1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = lvt_rf_pkg::clog2_min1(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0][DW-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem_q <= '0;
    else if (we) mem_q <= mem_d;
  end

  assign rdata = mem_q[raddr];

  // R1
  bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int DEPTH = 16,
  parameter int NWR   = 2,
  localparam int AW   = lvt_rf_pkg::clog2_min1(DEPTH),
  localparam int LW   = lvt_rf_pkg::clog2_min1(NWR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWR-1:0]          we,
  input  logic [NWR-1:0][AW-1:0]  waddr,
  output logic [DEPTH-1:0][LW-1:0] live_q
);
  logic [DEPTH-1:0][LW-1:0] live_d;
  logic                     any_we;

  assign any_we = |we;

  always_comb begin
    live_d = live_q;
    for (int w = 0; w < NWR; w++) begin
      if (we[w]) live_d[waddr[w]] = LW'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (any_we) live_q <= live_d;
  end

  // R6
  idle_table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_we |=> $stable(live_q));
  // R4
  collide_high_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && we[NWR-1] && waddr[0] == waddr[NWR-1]) |=>
      live_q[$past(waddr[NWR-1])] == LW'(NWR-1));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NWR   = 2,
  localparam int AW   = lvt_rf_pkg::clog2_min1(DEPTH),
  localparam int LW   = lvt_rf_pkg::clog2_min1(NWR)
) (
  input  logic [NWR-1:0][DW-1:0] bank_data,
  input  logic [LW-1:0]          live_sel,
  input  logic [AW-1:0]          raddr,
  input  logic [NWR-1:0]         we,
  input  logic [NWR-1:0][AW-1:0] waddr,
  input  logic [NWR-1:0][DW-1:0] wdata,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] stored;

  always_comb begin
    stored = bank_data[0];
    for (int w = 0; w < NWR; w++) begin
      if (live_sel == LW'(w)) stored = bank_data[w];
    end
  end

  always_comb begin
    rdata = stored;
    for (int w = 0; w < NWR; w++) begin
      if (we[w] && waddr[w] == raddr) rdata = wdata[w];
    end
  end
endmodule

// File: rtl/lvt_regfile.sv
module lvt_regfile #(
  parameter int DW    = lvt_rf_pkg::RF_DATA_W,
  parameter int DEPTH = lvt_rf_pkg::RF_DEPTH,
  parameter int NWR   = lvt_rf_pkg::RF_WR_PORTS,
  parameter int NRD   = lvt_rf_pkg::RF_RD_PORTS,
  localparam int AW   = lvt_rf_pkg::clog2_min1(DEPTH),
  localparam int LW   = lvt_rf_pkg::clog2_min1(NWR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NRD-1:0][NWR-1:0][DW-1:0] bank_rd;
  logic [DEPTH-1:0][LW-1:0]        live_q;

  lvt_table #(.DEPTH(DEPTH), .NWR(NWR)) u_live (
    .clk(clk), .rst_n(rst_int_n), .we(wr_en), .waddr(wr_addr), .live_q(live_q)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    for (genvar w = 0; w < NWR; w++) begin : g_wr
      rf_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_int_n), .we(wr_en[w]), .waddr(wr_addr[w]),
        .wdata(wr_data[w]), .raddr(rd_addr[r]), .rdata(bank_rd[r][w])
      );
    end
    rf_read_port #(.DW(DW), .DEPTH(DEPTH), .NWR(NWR)) u_port (
      .bank_data(bank_rd[r]), .live_sel(live_q[rd_addr[r]]), .raddr(rd_addr[r]),
      .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .rdata(rd_data[r])
    );

    // R3
    fwd_high_port_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en[NWR-1] && wr_addr[NWR-1] == rd_addr[r]) |-> rd_data[r] == wr_data[NWR-1]);
    // R2
    idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en == '0 && $past(wr_en) == '0 && $stable(rd_addr[r])) |-> $stable(rd_data[r]));
  end
endmodule

// File: tb/lvt_regfile_test.sv
module lvt_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEPTH = 16, NWR = 2, NRD = 4, AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NWR-1:0]          wr_en;
  logic [NWR-1:0][AW-1:0]  wr_addr;
  logic [NWR-1:0][DW-1:0]  wr_data;
  logic [NRD-1:0][AW-1:0]  rd_addr;
  logic [NRD-1:0][DW-1:0]  rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [DEPTH];

  lvt_regfile uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    logic [DW-1:0] v = model[a];
    for (int w = 0; w < NWR; w++) if (wr_en[w] && wr_addr[w] == a) v = wr_data[w];
    return v;
  endfunction

  // called just after a falling edge with inputs set: check, commit, return to falling edge
  task automatic cycle(input string tag);
    #1;
    for (int r = 0; r < NRD; r++) chk(rd_data[r], expect_rd(rd_addr[r]), tag);
    @(posedge clk);
    for (int w = 0; w < NWR; w++) if (wr_en[w]) model[wr_addr[w]] = wr_data[w];
    @(negedge clk);
  endtask

  task automatic set_rd(input int a0, input int a1, input int a2, input int a3);
    rd_addr[0] = AW'(a0); rd_addr[1] = AW'(a1); rd_addr[2] = AW'(a2); rd_addr[3] = AW'(a3);
  endtask

  task automatic idle();
    wr_en = '0;
  endtask

  task automatic t_reset();
    for (int b = 0; b < DEPTH; b += NRD) begin
      set_rd(b, b+1, b+2, b+3);
      cycle("R5 reset zero");
    end
  endtask

  task automatic t_dual_write();
    wr_en = 2'b11; wr_addr[0] = 4'd3; wr_data[0] = 32'hA0A0_0003;
    wr_addr[1] = 4'd9; wr_data[1] = 32'hB1B1_0009;
    set_rd(1, 2, 4, 5);
    cycle("R1 dual write cycle");
    idle(); set_rd(3, 9, 3, 9);
    cycle("R1 dual write readback");
    set_rd(9, 0, 3, 15);
    cycle("R2 mixed addresses");
  endtask

  task automatic t_forward();
    wr_en = 2'b01; wr_addr[0] = 4'd7; wr_data[0] = 32'hC0DE_0007;
    set_rd(7, 7, 6, 7);
    #1;
    chk(rd_data[0], 32'hC0DE_0007, "R3 forward port0");
    cycle("R3 forward port0");
    wr_en = 2'b10; wr_addr[1] = 4'd7; wr_data[1] = 32'hC0DE_1117;
    #1;
    chk(rd_data[1], 32'hC0DE_1117, "R3 forward port1");
    cycle("R3 forward port1");
    idle();
    cycle("R3 after forward");
  endtask

  task automatic t_collide();
    wr_en = 2'b11; wr_addr[0] = 4'd12; wr_data[0] = 32'h0000_AAAA;
    wr_addr[1] = 4'd12; wr_data[1] = 32'h1111_BBBB;
    set_rd(12, 12, 12, 12);
    #1;
    chk(rd_data[2], 32'h1111_BBBB, "R4 collision forward");
    cycle("R4 collision same cycle");
    idle();
    #1;
    chk(rd_data[3], 32'h1111_BBBB, "R4 collision stored");
    cycle("R4 collision next cycle");
  endtask

  task automatic t_disabled();
    wr_en = 2'b10; wr_addr[1] = 4'd5; wr_data[1] = 32'h5555_1111;
    set_rd(5, 5, 5, 5);
    cycle("R6 setup");
    wr_en = 2'b00; wr_addr[0] = 4'd5; wr_data[0] = 32'hDEAD_BEEF;
    wr_addr[1] = 4'd5; wr_data[1] = 32'hFEED_FACE;
    #1;
    chk(rd_data[0], 32'h5555_1111, "R6 no forward when disabled");
    cycle("R6 disabled write");
    idle();
    #1;
    chk(rd_data[1], 32'h5555_1111, "R6 value kept");
    cycle("R6 after disabled");
  endtask

  task automatic t_latest();
    wr_en = 2'b01; wr_addr[0] = 4'd5; wr_data[0] = 32'h0505_0000;
    cycle("R7 port0 over port1");
    idle(); set_rd(5, 12, 5, 12);
    #1;
    chk(rd_data[0], 32'h0505_0000, "R7 port0 latest");
    cycle("R7 readback");
    wr_en = 2'b10; wr_addr[1] = 4'd3; wr_data[1] = 32'h0303_1111;
    cycle("R7 port1 over port0");
    idle(); set_rd(3, 3, 9, 15);
    #1;
    chk(rd_data[1], 32'h0303_1111, "R7 port1 latest");
    cycle("R7 readback 2");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    #3;
    set_rd(0, 1, 2, 3);
    #1;
    for (int r = 0; r < NRD; r++) chk(rd_data[r], '0, "R5 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dual_write();
    t_forward();
    t_collide();
    t_disabled();
    t_latest();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule